// File: doc/BRIEF.md
# Single-Wire Bus Slave Transaction Sequencer

This block is the protocol layer of a slave on a single-wire, open-drain bus. A bit-slot layer below it reports each reset pulse it detects (`reset_seen`) and each received bit (`bit_valid` with `bit_in`). The sequencer makes sure every access follows a fixed order: a reset with a presence answer, then a ROM command with its data, then a function command. Traffic that breaks this order is ignored until the next reset.

After a reset the block asks the slot layer for a presence pulse. It then gathers an 8-bit ROM command, least-significant bit first, and acts on it. One command selects the device at once. One compares the next 64 bits against the device's ROM code. One counts 64 read slots. The two search-type commands, and any code the block does not know, park the block until a new reset. Once the device is selected, the next eight bits form the function command, which is handed up for execution.

Top module: `sw_slave_seq`

## Requirements
- R1: After `rst_n` is released, every output is 0. Bits that arrive before the first `reset_seen` produce no command and no selection.
- R2: `presence_req` is high for exactly the one cycle after each cycle in which `reset_seen` is high, and at no other time.
- R3: After a reset, the next eight bits form the ROM command, with the first bit landing in bit 0. `rom_cmd_valid` pulses for one cycle in the cycle after the eighth bit, and `rom_cmd` then holds the byte.
- R4: ROM command 0xCC sets `selected` in the same cycle as `rom_cmd_valid`. The next eight bits are then taken as the function command.
- R5: After ROM command 0x55, the next 64 bits are compared in order, the k-th received bit against `rom_code[k]`. If all 64 match, `selected` goes high and a function command is accepted.
- R6: After 0x55, any mismatching bit leaves `selected` low, and later bits produce no function command.
- R7: After ROM command 0x33, the block counts 64 bit slots regardless of their values. It then sets `selected` and accepts a function command.
- R8: After ROM command 0xF0 or 0xEC, `selected` stays low and no function command is accepted until the next `reset_seen`.
- R9: Any other ROM command byte sends the block to a state where it ignores all bits until the next `reset_seen`.
- R10: `reset_seen` aborts any phase and discards a partly received byte or ROM comparison. The eight bits that follow form a fresh ROM command.
- R11: `func_cmd_valid` pulses for one cycle in the cycle after the eighth function-command bit, and only while `selected` is high. `func_cmd` carries the byte, least-significant bit first. Bits after that byte produce nothing until the next reset.
- R12: `selected` is low in the cycle after any `reset_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_seen | input | 1 | One-cycle strobe: the slot layer has detected a bus reset pulse |
| bit_valid | input | 1 | One-cycle strobe: `bit_in` holds a received bit |
| bit_in | input | 1 | Received bit value |
| rom_code | input | 64 | The device's unique ROM code; bit 0 is compared first |
| presence_req | output | 1 | Request to the slot layer to drive a presence pulse |
| rom_cmd | output | 8 | Last ROM command byte received |
| rom_cmd_valid | output | 1 | One-cycle strobe: `rom_cmd` has just been updated |
| selected | output | 1 | The device is addressed in the current transaction |
| func_cmd | output | 8 | Last function command byte received |
| func_cmd_valid | output | 1 | One-cycle strobe: `func_cmd` has just been updated |

## Verification
The sequencer is driven with complete transactions through each of the three selecting ROM commands. Comparing their outcomes separates the immediate selection, the 64-bit compare and the 64-slot count. A Match with a single flipped code bit deep in the word shows that every bit is compared, not just the first few. The search codes, an unknown code and bits sent before any reset show that the block falls silent where it should. Resets dropped mid-byte and mid-compare show that partial state is thrown away, because the byte that follows must decode cleanly.

// File: rtl/sw_seq_pkg.sv
package sw_seq_pkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ_ROM  = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH_ROM = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SKIP_ROM  = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_SEARCH    = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_ALM_SRCH  = 8'hEC;

  typedef enum logic [2:0] {
    ST_WAIT_RST,
    ST_ROM_CMD,
    ST_ROM_MATCH,
    ST_ROM_READ,
    ST_FUNC_CMD,
    ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    RT_HALT,
    RT_FUNC,
    RT_MATCH,
    RT_READ
  } rom_route_e;

  // Where a ROM command byte sends the sequencer next.
  function automatic rom_route_e route_rom_cmd(input logic [CMD_W-1:0] code);
    rom_route_e r;
    case (code)
      CMD_SKIP_ROM:  r = RT_FUNC;
      CMD_MATCH_ROM: r = RT_MATCH;
      CMD_READ_ROM:  r = RT_READ;
      default:       r = RT_HALT;   // search, alarm search, unknown
    endcase
    return r;
  endfunction

  function automatic logic is_search_code(input logic [CMD_W-1:0] code);
    return (code == CMD_SEARCH) || (code == CMD_ALM_SRCH);
  endfunction

endpackage

// File: rtl/sw_bit_shifter.sv
module sw_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  sh_next;

  // LSB first: each new bit enters at the top and moves down.
  assign sh_next = {bit_in, sh_q[W-1:1]};
  assign word    = sh_next;
  assign done    = shift_en && !clear && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (shift_en) begin
      sh_q  <= sh_next;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/sw_rom_cmp.sv
module sw_rom_cmp #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         cmp_en,
  input  logic         bit_in,
  input  logic [N-1:0] rom_code,
  output logic         mismatch,
  output logic         last
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  logic [IW-1:0] idx_q;
  logic          exp_bit;

  assign exp_bit  = rom_code[idx_q];
  assign mismatch = step && !clear && cmp_en && (bit_in != exp_bit);
  assign last     = step && !clear && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (clear)    idx_q <= '0;
    else if (step)     idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  // R10
  cmp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx_q == '0));

endmodule

// File: rtl/sw_slave_seq.sv
module sw_slave_seq
  import sw_seq_pkg::*;
#(
  parameter int ROM_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reset_seen,
  input  logic                bit_valid,
  input  logic                bit_in,
  input  logic [ROM_BITS-1:0] rom_code,
  output logic                presence_req,
  output logic [CMD_W-1:0]    rom_cmd,
  output logic                rom_cmd_valid,
  output logic                selected,
  output logic [CMD_W-1:0]    func_cmd,
  output logic                func_cmd_valid
);

  seq_state_e state_q;

  logic             in_byte_phase;
  logic             in_rom_phase;
  logic             byte_done;
  logic [CMD_W-1:0] byte_word;
  logic             rom_byte_done;
  logic             func_byte_done;
  logic             rom_step;
  logic             rom_mismatch;
  logic             rom_last;
  rom_route_e       route;

  assign in_byte_phase  = (state_q == ST_ROM_CMD) || (state_q == ST_FUNC_CMD);
  assign in_rom_phase   = (state_q == ST_ROM_MATCH) || (state_q == ST_ROM_READ);
  assign rom_step       = bit_valid && in_rom_phase;
  assign rom_byte_done  = byte_done && (state_q == ST_ROM_CMD);
  assign func_byte_done = byte_done && (state_q == ST_FUNC_CMD);
  assign route          = route_rom_cmd(byte_word);

  sw_bit_shifter #(.W(CMD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (reset_seen),
    .shift_en (bit_valid && in_byte_phase),
    .bit_in   (bit_in),
    .done     (byte_done),
    .word     (byte_word)
  );

  sw_rom_cmp #(.N(ROM_BITS)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (reset_seen),
    .step     (rom_step),
    .cmp_en   (state_q == ST_ROM_MATCH),
    .bit_in   (bit_in),
    .rom_code (rom_code),
    .mismatch (rom_mismatch),
    .last     (rom_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_WAIT_RST;
      presence_req   <= 1'b0;
      rom_cmd        <= '0;
      rom_cmd_valid  <= 1'b0;
      selected       <= 1'b0;
      func_cmd       <= '0;
      func_cmd_valid <= 1'b0;
    end else begin
      presence_req   <= reset_seen;
      rom_cmd_valid  <= 1'b0;
      func_cmd_valid <= 1'b0;
      if (reset_seen) begin
        state_q  <= ST_ROM_CMD;
        selected <= 1'b0;
      end else begin
        case (state_q)
          ST_ROM_CMD: if (rom_byte_done) begin
            rom_cmd       <= byte_word;
            rom_cmd_valid <= 1'b1;
            case (route)
              RT_FUNC:  begin state_q <= ST_FUNC_CMD; selected <= 1'b1; end
              RT_MATCH: state_q <= ST_ROM_MATCH;
              RT_READ:  state_q <= ST_ROM_READ;
              default:  state_q <= ST_HALT;
            endcase
          end
          ST_ROM_MATCH: if (rom_mismatch) begin
            state_q <= ST_HALT;
          end else if (rom_last) begin
            state_q  <= ST_FUNC_CMD;
            selected <= 1'b1;
          end
          ST_ROM_READ: if (rom_last) begin
            state_q  <= ST_FUNC_CMD;
            selected <= 1'b1;
          end
          ST_FUNC_CMD: if (func_byte_done) begin
            func_cmd       <= byte_word;
            func_cmd_valid <= selected;
            state_q        <= ST_HALT;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  presence_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> presence_req);

  // R2
  presence_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presence_req |-> $past(reset_seen));

  // R12
  reset_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> !selected);

  // R11
  func_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_cmd_valid |-> selected);

  // R4
  skip_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cmd_valid && rom_cmd == CMD_SKIP_ROM) |-> selected);

  // R8
  search_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cmd_valid && is_search_code(rom_cmd)) |-> (state_q == ST_HALT && !selected));

  // R3
  rom_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cmd_valid |=> !rom_cmd_valid);

endmodule

// File: tb/sw_slave_seq_tb.sv
module sw_slave_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EV_PRES = 0;
  localparam int EV_ROM  = 1;
  localparam int EV_FUNC = 2;
  localparam logic [63:0] CODE = 64'h8A3C_5E91_0F27_D46B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_seen = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [63:0] rom_code = CODE;
  logic        presence_req, rom_cmd_valid, selected, func_cmd_valid;
  logic [7:0]  rom_cmd, func_cmd;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  int         q_kind[$];
  logic [7:0] q_val[$];
  string      q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_slave_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reset_seen(reset_seen), .bit_valid(bit_valid),
    .bit_in(bit_in), .rom_code(rom_code), .presence_req(presence_req),
    .rom_cmd(rom_cmd), .rom_cmd_valid(rom_cmd_valid), .selected(selected),
    .func_cmd(func_cmd), .func_cmd_valid(func_cmd_valid)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [7:0] val, input string req);
    q_kind.push_back(kind);
    q_val.push_back(val);
    q_req.push_back(req);
  endtask

  task automatic observe(input int kind, input logic [7:0] val);
    checks++;
    if (q_kind.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected event kind=%0d val=%h expected=none", cur_req, kind, val);
    end else begin
      int ek = q_kind.pop_front();
      logic [7:0] ev = q_val.pop_front();
      string er = q_req.pop_front();
      if (ek != kind || ev != val) begin
        fails++;
        $display("FAIL %s event actual=%0d/%h expected=%0d/%h", er, kind, val, ek, ev);
      end
    end
  endtask

  // Monitor: compares design events against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (presence_req)   observe(EV_PRES, 8'h00);
      if (rom_cmd_valid)  observe(EV_ROM, rom_cmd);
      if (func_cmd_valid) begin
        observe(EV_FUNC, func_cmd);
        check("R11", "selected at func_cmd_valid", int'(selected), 1);
      end
    end
  end

  task automatic send_reset();
    expect_ev(EV_PRES, 8'h00, "R2");
    @(posedge clk); #1 reset_seen = 1'b1;
    @(posedge clk); #1 reset_seen = 1'b0;
    @(negedge clk);
    check("R2", "presence_req after reset_seen", int'(presence_req), 1);
    check("R12", "selected after reset_seen", int'(selected), 0);
    @(negedge clk);
    check("R2", "presence_req second cycle", int'(presence_req), 0);
  endtask

  task automatic send_bit(input logic b);
    @(posedge clk); #1 bit_valid = 1'b1; bit_in = b;
    @(posedge clk); #1 bit_valid = 1'b0; bit_in = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_code(input logic [63:0] c);
    for (int i = 0; i < 64; i++) send_bit(c[i]);
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    check(req, "pending expected events", q_kind.size(), 0);
  endtask

  task automatic check_sel(input string req, input int exp);
    @(negedge clk);
    check(req, "selected", int'(selected), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, bits before any bus reset are ignored
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "outputs during reset", {presence_req, rom_cmd_valid, selected, func_cmd_valid}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", {presence_req, rom_cmd_valid, selected, func_cmd_valid, rom_cmd, func_cmd}, 0);
    send_byte(8'hCC);
    send_byte(8'h44);
    check_sel("R1", 0);
    drain("R1");

    // R3 R4 R11: skip then function byte, further bits ignored
    cur_req = "R11";
    send_reset();
    expect_ev(EV_ROM, 8'hCC, "R3");
    send_byte(8'hCC);
    check_sel("R4", 1);
    expect_ev(EV_FUNC, 8'h44, "R11");
    send_byte(8'h44);
    send_byte(8'hBE);
    drain("R11");
    check("R3", "rom_cmd holds", int'(rom_cmd), 8'hCC);

    // R5: full match
    cur_req = "R5";
    send_reset();
    expect_ev(EV_ROM, 8'h55, "R5");
    send_byte(8'h55);
    send_code(CODE);
    check_sel("R5", 1);
    expect_ev(EV_FUNC, 8'hB8, "R5");
    send_byte(8'hB8);
    drain("R5");

    // R6: one flipped bit deep in the code
    cur_req = "R6";
    send_reset();
    expect_ev(EV_ROM, 8'h55, "R6");
    send_byte(8'h55);
    send_code(CODE ^ (64'h1 << 37));
    check_sel("R6", 0);
    send_byte(8'hB8);
    drain("R6");

    // R7: read ROM counts 64 slots
    cur_req = "R7";
    send_reset();
    expect_ev(EV_ROM, 8'h33, "R7");
    send_byte(8'h33);
    send_code(64'h0);
    check_sel("R7", 1);
    expect_ev(EV_FUNC, 8'h4E, "R7");
    send_byte(8'h4E);
    drain("R7");

    // R8: search and alarm search park the block
    cur_req = "R8";
    send_reset();
    expect_ev(EV_ROM, 8'hF0, "R8");
    send_byte(8'hF0);
    send_byte(8'hCC);
    send_byte(8'h44);
    check_sel("R8", 0);
    drain("R8");
    send_reset();
    expect_ev(EV_ROM, 8'hEC, "R8");
    send_byte(8'hEC);
    send_byte(8'h44);
    check_sel("R8", 0);
    drain("R8");

    // R9: unknown code
    cur_req = "R9";
    send_reset();
    expect_ev(EV_ROM, 8'hA5, "R9");
    send_byte(8'hA5);
    send_byte(8'hCC);
    send_byte(8'h44);
    check_sel("R9", 0);
    drain("R9");

    // R10: reset mid-byte and mid-compare
    cur_req = "R10";
    send_reset();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_reset();
    expect_ev(EV_ROM, 8'hCC, "R10");
    send_byte(8'hCC);
    check_sel("R10", 1);
    send_reset();
    expect_ev(EV_ROM, 8'h55, "R10");
    send_byte(8'h55);
    for (int i = 0; i < 20; i++) send_bit(CODE[i]);
    send_reset();
    expect_ev(EV_ROM, 8'h55, "R10");
    send_byte(8'h55);
    send_code(CODE);
    check_sel("R10", 1);
    expect_ev(EV_FUNC, 8'h69, "R10");
    send_byte(8'h69);
    drain("R10");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule